// File: doc/BRIEF.md
# FIFO DMA Request Handshake Controller

This block decides when a parallel-port receive FIFO, which drains towards the host, asks for service. It has two modes. In DMA mode it drives a request line towards the host DMA controller. In interrupt-driven programmed I/O mode it raises an interrupt instead, once the FIFO fill level reaches a software threshold. The mode comes from two software bits: an enable bit and a service bit. The controller can set the service bit itself through a hardware set strobe.

While a DMA transfer runs, the block watches the active-low acknowledge, the host read strobe and the terminal-count signal. It synchronises these three inputs to its clock first. It drops the request for the final byte in the FIFO. It caps each burst so that the host bus is not held too long, and after a cap it waits for a minimum acknowledge-idle time before asking again. On a qualified terminal count it stops the transfer, raises an interrupt and sets the service bit, so that software must re-arm DMA explicitly.

Top module: `fifo_dreq_ctrl`

## Requirements
- R1: The request output is high only in DMA mode, which is the enable bit at 1 with the service bit at 0. In every other combination of the two bits the request stays low.
- R2: In DMA mode the request is high while the FIFO level is at least 1 and low while the level is 0. After an empty period, one byte is enough to raise it again.
- R3: In programmed I/O mode (enable 0, service 0) the interrupt is high while the FIFO level is at or above the effective threshold, and the request stays low. A threshold of 0 acts as 1.
- R4: Any threshold above 15, for example 16 or 31, behaves exactly like 15.
- R5: A terminal count seen while the acknowledge is low removes the request. It also gives a one-cycle interrupt pulse and a one-cycle service-set pulse. A terminal count seen while the acknowledge is high has no effect.
- R6: After a terminal-count stop, the request stays low until the service bit has been observed at 1. After that it needs the service bit back at 0 and a FIFO level of at least 1.
- R7: A falling acknowledge while the FIFO level is 1 drops the request even though the level is still 1. A falling read strobe at level 1 does the same. The request then stays low until the level has reached 0.
- R8: The request drops on the 32nd falling acknowledge of an uninterrupted burst. The 31st does not drop it. The burst count restarts whenever the request goes low.
- R9: After a burst cap the request stays low until the acknowledge has been high for 18 consecutive synchronised cycles (350 ns at a 20 ns clock, rounded up). Any low acknowledge restarts that wait. The request rises 21 clock edges after the acknowledge pin rises.
- R10: Setting the service bit and then clearing the enable bit in the middle of a burst drops the request, and the request stays low. No interrupt is raised.
- R11: While reset is active, the request, the interrupt and the service-set strobe are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | LEVEL_W | Number of bytes held in the FIFO |
| dma_en | input | 1 | Software DMA enable bit |
| svc_bit | input | 1 | Software service bit (1 blocks both DMA and programmed I/O service) |
| dack_n | input | 1 | Active-low DMA acknowledge from the host, asynchronous |
| rd_n | input | 1 | Active-low host read strobe, asynchronous |
| tc | input | 1 | Terminal count from the host DMA controller, asynchronous |
| pio_thr | input | THR_W | Programmed I/O interrupt threshold |
| dreq | output | 1 | DMA request |
| irq | output | 1 | Interrupt (level in programmed I/O mode, pulse on terminal count) |
| svc_set | output | 1 | One-cycle strobe that sets the service bit |

## Verification
The assertions assume the following about the inputs. The level, enable, service and threshold inputs are synchronous and stable between edges. A terminal count arrives only while a transfer is running. The service register outside the block takes the set strobe within a few cycles. The stimulus drives every input on the falling clock edge. It holds each acknowledge and read-strobe level for at least two clocks, so that the synchroniser sees every edge. It models the service register by writing the service bit only after the set strobe has been observed. It changes the FIFO level only where a real drain would.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_DRAIN  = 2'd1,
      ST_TCWAIT = 2'd2,
      ST_GAP    = 2'd3
   } fdc_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/fdc_sync.sv
module fdc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fdc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL}};
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/fdc_burst_ctr.sv
module fdc_burst_ctr #(
   parameter int BURST_MAX = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   output logic at_limit
);
   localparam int CW = $clog2(BURST_MAX + 1);

   generate
      if (BURST_MAX < 2) begin : g_bad_burst
         $error("fdc_burst_ctr needs BURST_MAX of at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (inc)   cnt <= cnt + 1'b1;
   end

   assign at_limit = (cnt == CW'(BURST_MAX - 1));

   // R8
   burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(BURST_MAX));
endmodule

// File: rtl/fdc_gap_timer.sv
module fdc_gap_timer #(
   parameter int IDLE_CYC = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ack_idle,
   output logic done
);
   localparam int GW = $clog2(IDLE_CYC + 1);

   generate
      if (IDLE_CYC < 1) begin : g_bad_idle
         $error("fdc_gap_timer needs IDLE_CYC of at least 1");
      end
   endgenerate

   logic [GW-1:0] cnt;

   assign done = run && ack_idle && (cnt == GW'(IDLE_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || !ack_idle) cnt <= '0;
      else if (!done)            cnt <= cnt + 1'b1;
   end

   generate
      if (IDLE_CYC >= 2) begin : g_idle_chk
         // R9
         gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> $past(ack_idle));
      end
   endgenerate
endmodule

// File: rtl/fdc_pio_thresh.sv
module fdc_pio_thresh #(
   parameter int LEVEL_W = 5,
   parameter int THR_W   = 5,
   parameter int THR_MAX = 15
) (
   input  logic [LEVEL_W-1:0] level,
   input  logic [THR_W-1:0]   thr,
   output logic               hit
);
   localparam int CW = ((LEVEL_W > THR_W) ? LEVEL_W : THR_W) + 1;

   generate
      if (THR_MAX < 1 || THR_MAX >= (2 ** (CW - 1))) begin : g_bad_max
         $error("fdc_pio_thresh THR_MAX out of range");
      end
   endgenerate

   logic [CW-1:0] thr_c, lim, eff;

   assign thr_c = CW'(thr);

   generate
      if ((2 ** THR_W) - 1 > THR_MAX) begin : g_clamp
         assign lim = (thr_c > CW'(THR_MAX)) ? CW'(THR_MAX) : thr_c;
      end else begin : g_pass
         assign lim = thr_c;
      end
   endgenerate

   assign eff = (lim == '0) ? CW'(1) : lim;
   assign hit = (CW'(level) >= eff);
endmodule

// File: rtl/fifo_dreq_ctrl.sv
module fifo_dreq_ctrl
   import fdc_pkg::*;
#(
   parameter int LEVEL_W       = 5,
   parameter int THR_W         = 5,
   parameter int THR_MAX       = 15,
   parameter int BURST_MAX     = 32,
   parameter int CLK_PERIOD_NS = 20,
   parameter int IDLE_NS       = 350,
   parameter int SYNC_STAGES   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic               dma_en,
   input  logic               svc_bit,
   input  logic               dack_n,
   input  logic               rd_n,
   input  logic               tc,
   input  logic [THR_W-1:0]   pio_thr,
   output logic               dreq,
   output logic               irq,
   output logic               svc_set
);
   localparam int IDLE_CYC = ceil_div(IDLE_NS, CLK_PERIOD_NS);
   localparam int NSYNC    = 3;
   localparam logic [NSYNC-1:0] SYNC_RST = 3'b011;

   generate
      if (LEVEL_W < 1 || CLK_PERIOD_NS < 1) begin : g_bad_top
         $error("fifo_dreq_ctrl parameter out of range");
      end
   endgenerate

   // synchronisers: bit 0 acknowledge, bit 1 read strobe, bit 2 terminal count
   logic [NSYNC-1:0] raw, syn;
   assign raw = {tc, rd_n, dack_n};

   generate
      for (genvar i = 0; i < NSYNC; i++) begin : g_sync
         fdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[i])) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(syn[i]));
      end
   endgenerate

   logic ack_s, rd_s, tc_s, ack_q, rd_q;
   assign ack_s = syn[0];
   assign rd_s  = syn[1];
   assign tc_s  = syn[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b1;
         rd_q  <= 1'b1;
      end else begin
         ack_q <= ack_s;
         rd_q  <= rd_s;
      end
   end

   logic ack_fall, rd_fall;
   assign ack_fall = ack_q & ~ack_s;
   assign rd_fall  = rd_q & ~rd_s;

   logic dma_mode, pio_mode, has_data, one_left;
   assign dma_mode = dma_en & ~svc_bit;
   assign pio_mode = ~dma_en & ~svc_bit;
   assign has_data = |fifo_level;
   assign one_left = (fifo_level == LEVEL_W'(1));

   fdc_state_e st, st_n;
   logic at_limit, gap_done, dreq_d;
   logic tc_evt, cap_evt, last_evt, pio_hit;

   assign tc_evt   = dma_mode && tc_s && !ack_s && (st == ST_RUN || st == ST_DRAIN);
   assign cap_evt  = (st == ST_RUN) && dreq && ack_fall && at_limit;
   assign last_evt = (st == ST_RUN) && dreq && one_left && (ack_fall || rd_fall);

   fdc_burst_ctr #(.BURST_MAX(BURST_MAX)) u_burst (
      .clk(clk), .rst_n(rst_n), .clear(!dreq_d),
      .inc(ack_fall && dreq), .at_limit(at_limit));

   fdc_gap_timer #(.IDLE_CYC(IDLE_CYC)) u_gap (
      .clk(clk), .rst_n(rst_n), .run(st == ST_GAP),
      .ack_idle(ack_s), .done(gap_done));

   fdc_pio_thresh #(.LEVEL_W(LEVEL_W), .THR_W(THR_W), .THR_MAX(THR_MAX)) u_thr (
      .level(fifo_level), .thr(pio_thr), .hit(pio_hit));

   always_comb begin
      st_n = st;
      unique case (st)
         ST_RUN: begin
            if (tc_evt)         st_n = ST_TCWAIT;
            else if (!dma_mode) st_n = ST_RUN;
            else if (cap_evt)   st_n = ST_GAP;
            else if (last_evt)  st_n = ST_DRAIN;
         end
         ST_DRAIN: begin
            if (tc_evt)                      st_n = ST_TCWAIT;
            else if (!dma_mode || !has_data) st_n = ST_RUN;
         end
         ST_TCWAIT: begin
            if (svc_bit || !dma_en) st_n = ST_RUN;
         end
         ST_GAP: begin
            if (!dma_mode || gap_done) st_n = ST_RUN;
         end
         default: st_n = ST_RUN;
      endcase
   end

   assign dreq_d = (st == ST_RUN) && dma_mode && has_data &&
                   !tc_evt && !cap_evt && !last_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_RUN;
         dreq    <= 1'b0;
         irq     <= 1'b0;
         svc_set <= 1'b0;
      end else begin
         st      <= st_n;
         dreq    <= dreq_d;
         irq     <= (pio_mode && pio_hit) || tc_evt;
         svc_set <= tc_evt;
      end
   end

   // R1
   dreq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_en || svc_bit) |=> !dreq);

   // R2
   dreq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level == '0) |=> !dreq);

   // R5
   tc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_set |-> (!dreq && irq));

   // R5
   tc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_set |=> !svc_set);
endmodule

// File: tb/fifo_dreq_ctrl_tb.sv
module fifo_dreq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] fifo_level = '0;
   logic       dma_en = 1'b0;
   logic       svc_bit = 1'b0;
   logic       dack_n = 1'b1;
   logic       rd_n = 1'b1;
   logic       tc = 1'b0;
   logic [4:0] pio_thr = 5'd4;
   logic       dreq, irq, svc_set;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fifo_dreq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .dma_en(dma_en),
      .svc_bit(svc_bit), .dack_n(dack_n), .rd_n(rd_n), .tc(tc),
      .pio_thr(pio_thr), .dreq(dreq), .irq(irq), .svc_set(svc_set));

   // vector layout: {level[4:0], en, svc, thr[4:0], exp_dreq, exp_irq}
   localparam int NV = 12;
   localparam logic [13:0] VEC [NV] = '{
      {5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0},  // R2 data present
      {5'd0,  1'b1, 1'b0, 5'd4,  1'b0, 1'b0},  // R2 empty
      {5'd3,  1'b1, 1'b1, 5'd4,  1'b0, 1'b0},  // R1 service bit set
      {5'd3,  1'b0, 1'b1, 5'd4,  1'b0, 1'b0},  // R1 both off
      {5'd5,  1'b0, 1'b0, 5'd4,  1'b0, 1'b1},  // R3 above threshold
      {5'd3,  1'b0, 1'b0, 5'd4,  1'b0, 1'b0},  // R3 below threshold
      {5'd15, 1'b0, 1'b0, 5'd16, 1'b0, 1'b1},  // R4 16 acts as 15
      {5'd14, 1'b0, 1'b0, 5'd16, 1'b0, 1'b0},  // R4 16 acts as 15
      {5'd15, 1'b0, 1'b0, 5'd31, 1'b0, 1'b1},  // R4 31 acts as 15
      {5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0},  // R3 zero threshold
      {5'd1,  1'b0, 1'b0, 5'd0,  1'b0, 1'b1},  // R3 zero acts as 1
      {5'd1,  1'b1, 1'b0, 5'd0,  1'b1, 1'b0}   // R2 single byte
   };
   localparam int VREQ [NV] = '{2, 2, 1, 1, 3, 3, 4, 4, 4, 3, 3, 2};

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R11 reset state with active-looking inputs
      fifo_level = 5'd5; dma_en = 1'b1;
      step(3);
      chk("R11 dreq in reset", dreq, 1'b0);
      chk("R11 irq in reset", irq, 1'b0);
      chk("R11 svc_set in reset", svc_set, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         fifo_level = VEC[i][13:9];
         dma_en     = VEC[i][8];
         svc_bit    = VEC[i][7];
         pio_thr    = VEC[i][6:2];
         step(3);
         chk($sformatf("R%0d vector %0d dreq", VREQ[i], i), dreq, VEC[i][1]);
         chk($sformatf("R%0d vector %0d irq", VREQ[i], i), irq, VEC[i][0]);
      end

      // R5: terminal count with acknowledge high is ignored
      fifo_level = 5'd5; dma_en = 1'b1; svc_bit = 1'b0; pio_thr = 5'd4;
      step(3);
      chk("R5 dreq before tc", dreq, 1'b1);
      tc = 1'b1;
      step(4);
      chk("R5 tc without ack keeps dreq", dreq, 1'b1);
      chk("R5 tc without ack no svc_set", svc_set, 1'b0);
      // R5: qualified terminal count
      dack_n = 1'b0;
      step(3);
      chk("R5 tc drops dreq", dreq, 1'b0);
      chk("R5 tc svc_set pulse", svc_set, 1'b1);
      chk("R5 tc irq pulse", irq, 1'b1);
      step(1);
      chk("R5 svc_set one cycle", svc_set, 1'b0);
      chk("R5 irq one cycle", irq, 1'b0);
      // R6: software model takes the set strobe
      svc_bit = 1'b1; tc = 1'b0; dack_n = 1'b1;
      step(4);
      chk("R6 dreq low while service set", dreq, 1'b0);
      fifo_level = 5'd0; svc_bit = 1'b0;
      step(3);
      chk("R6 cleared but empty", dreq, 1'b0);
      fifo_level = 5'd2;
      step(3);
      chk("R6 re-armed with data", dreq, 1'b1);

      // R7: last byte via acknowledge
      fifo_level = 5'd1;
      step(2);
      dack_n = 1'b0;
      step(3);
      chk("R7 ack on last byte drops dreq", dreq, 1'b0);
      step(3);
      chk("R7 held while level still 1", dreq, 1'b0);
      dack_n = 1'b1; fifo_level = 5'd0;
      step(3);
      chk("R2 empty after last byte", dreq, 1'b0);
      fifo_level = 5'd1;
      step(3);
      chk("R2 one byte returns dreq", dreq, 1'b1);
      // R7: last byte via read strobe
      rd_n = 1'b0;
      step(3);
      chk("R7 read strobe on last byte", dreq, 1'b0);
      rd_n = 1'b1;
      step(3);
      chk("R7 read strobe hold", dreq, 1'b0);
      fifo_level = 5'd0;
      step(2);
      fifo_level = 5'd10;
      step(3);
      chk("R2 refill after drain", dreq, 1'b1);

      // R8: burst cap
      for (int p = 0; p < 31; p++) begin
         dack_n = 1'b0; step(2);
         dack_n = 1'b1; step(2);
      end
      step(2);
      chk("R8 31 acks keep dreq", dreq, 1'b1);
      dack_n = 1'b0;
      step(3);
      chk("R8 32nd ack drops dreq", dreq, 1'b0);
      step(25);
      chk("R9 ack still low holds dreq", dreq, 1'b0);
      // R9: idle wait restarted by a low acknowledge
      dack_n = 1'b1;
      step(12);
      chk("R9 early in idle wait", dreq, 1'b0);
      dack_n = 1'b0;
      step(2);
      chk("R9 restart low", dreq, 1'b0);
      dack_n = 1'b1;
      step(20);
      chk("R9 one edge before idle end", dreq, 1'b0);
      step(1);
      chk("R9 dreq after idle end", dreq, 1'b1);

      // R10: mid-stream software stop
      fifo_level = 5'd6;
      dack_n = 1'b0; step(2);
      dack_n = 1'b1; step(2);
      svc_bit = 1'b1;
      step(1);
      dma_en = 1'b0;
      step(3);
      chk("R10 stop drops dreq", dreq, 1'b0);
      chk("R10 stop no irq", irq, 1'b0);
      step(5);
      chk("R10 stays stopped", dreq, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule